// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block turns a decoded three-level PWM command into on-requests for the upper and lower switches of a half-bridge. A high command selects the upper switch. A low command selects the lower switch. A mid command asks for both switches off, either to brake or to idle. On every change of direction, the gate that is on is dropped first. The opposite gate is raised only after a dead gap, which comes from one of two sources. In adaptive mode the gap ends when a digital flag reports that the released gate has discharged. A watchdog bounds that wait. In fixed mode the gap is a programmed count of clock cycles, set separately for each direction.

A light-load mode emulates a diode on the low side. In this mode the lower switch is released when the inductor current crosses zero. The lower switch is also held on for a minimum time, even when a mid command arrives early. While the block is disabled or the supply is not good, both gates stay off. All delays are given in nanoseconds and converted to clock cycles by rounding up.

Top module: `hb_gate_seq`

## Requirements
- R1: While `en` or `pgood` is low, both outputs are low on the next rising edge and stay low whatever `pwm_cmd` does. Both outputs are also low while `rst_n` is low.
- R2: In fixed mode, a high command (`pwm_cmd` = 2'b01) drops `lo_on` on the next edge. `up_on` then rises after exactly N edges with both outputs low, where N = ceil(lo-to-up ns / CLK_NS).
- R3: In fixed mode, a low command (`pwm_cmd` = 2'b00) drops `up_on` on the next edge. `lo_on` then rises after exactly ceil(up-to-lo ns / CLK_NS) cycles with both outputs low.
- R4: `up_on` and `lo_on` are never high in the same cycle.
- R5: A mid command (`pwm_cmd` = 2'b10 or 2'b11) drives both outputs low on the next edge. The one exception is R7.
- R6: With `de_mode` high, a sampled `zero_cross` releases `lo_on` on the next edge once the minimum on-time has passed. The lower gate then stays off for as long as the command stays low. With `de_mode` low, `zero_cross` is ignored.
- R7: With `de_mode` high, `lo_on` stays high for at least ceil(MIN_ON_NS / CLK_NS) cycles before a mid command or `zero_cross` can release it. A high command is not delayed by this hold.
- R8: In adaptive mode (`dt_strap` = 2'b00 or 2'b11), the pending gate rises on the edge after the discharge flag of the released gate (`lo_dis` for upper, `up_dis` for lower) is sampled high. If the flag never arrives, the gate rises after ceil(WAIT_NS / CLK_NS) gap cycles.
- R9: If the command reverses during a gap, the pending turn-on is cancelled. A new gap with the opposite direction's delay begins.
- R10: In fixed mode the two delays come from `dt_strap` and `dt_code`. With `dt_strap` = 2'b10, codes 0..3 give 27 ns lo-to-up and 23, 18, 15, 7 ns up-to-lo. With `dt_strap` = 2'b01, codes 0..3 give 40, 25, 17, 17 ns lo-to-up and 18 ns up-to-lo.
- R11: When `en` or `pgood` returns, the first command starts from both-off and goes through a full dead gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Driver enable |
| pgood | input | 1 | Supply-good flag |
| pwm_cmd | input | 2 | Decoded command: 00 low, 01 high, 1x mid |
| de_mode | input | 1 | Diode-emulation mode select |
| zero_cross | input | 1 | Inductor current reached zero |
| dt_strap | input | 2 | Dead-time mode: 00/11 adaptive, 01 ground-tied, 10 supply-tied |
| dt_code | input | 2 | Fixed-delay code within the strap setting |
| up_dis | input | 1 | Upper gate discharged |
| lo_dis | input | 1 | Lower gate discharged |
| up_on | output | 1 | Upper gate on-request |
| lo_on | output | 1 | Lower gate on-request |

## Verification
The assertions assume that every input is synchronous to `clk` and settled at the rising edge. They do not assume that the discharge flags follow the outputs. The flags may stay high, stay low, or change at any time, and the checks must still hold. The stimulus changes inputs only on the falling edge and leaves each command in place long enough to see its effect. The dead-time, watchdog and minimum-hold counts are restated in the stimulus from the nanosecond table and the rounding rule.

// File: rtl/hb_gate_pkg.sv
`timescale 1ns/1ps
package hb_gate_pkg;

  typedef enum logic [2:0] {
    S_OFF    = 3'd0,
    S_GAP_UP = 3'd1,
    S_UP     = 3'd2,
    S_GAP_LO = 3'd3,
    S_LO     = 3'd4,
    S_ZC     = 3'd5
  } seq_state_e;

  localparam logic [1:0] STRAP_OPEN = 2'b00;
  localparam logic [1:0] STRAP_GND  = 2'b01;
  localparam logic [1:0] STRAP_VCC  = 2'b10;

  localparam int unsigned DT_NS_MAX = 40;

  typedef struct packed {
    logic [7:0] lo2up_ns;
    logic [7:0] up2lo_ns;
  } dt_ns_t;

  // ceiling division, never below one cycle, so a gap is never shortened
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic dt_ns_t dt_lookup(logic [1:0] strap, logic [1:0] code);
    dt_ns_t p;
    if (strap == STRAP_VCC) begin
      p.lo2up_ns = 8'd27;
      case (code)
        2'd0:    p.up2lo_ns = 8'd23;
        2'd1:    p.up2lo_ns = 8'd18;
        2'd2:    p.up2lo_ns = 8'd15;
        default: p.up2lo_ns = 8'd7;
      endcase
    end else begin
      p.up2lo_ns = 8'd18;
      case (code)
        2'd0:    p.lo2up_ns = 8'd40;
        2'd1:    p.lo2up_ns = 8'd25;
        default: p.lo2up_ns = 8'd17;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/hb_dt_table.sv
`timescale 1ns/1ps
module hb_dt_table import hb_gate_pkg::*; #(
  parameter int unsigned CLK_NS   = 4,
  parameter int unsigned WAIT_CYC = 25,
  parameter int unsigned GW       = 5
) (
  input  logic [1:0]    dt_strap,
  input  logic [1:0]    dt_code,
  output logic          adaptive,
  output logic [GW-1:0] lo2up_cyc,
  output logic [GW-1:0] up2lo_cyc
);
  dt_ns_t pair;

  always_comb begin
    pair     = dt_lookup(dt_strap, dt_code);
    adaptive = !(dt_strap == STRAP_GND || dt_strap == STRAP_VCC);
    if (adaptive) begin
      lo2up_cyc = GW'(WAIT_CYC);
      up2lo_cyc = GW'(WAIT_CYC);
    end else begin
      lo2up_cyc = GW'(ns_to_cyc(32'(pair.lo2up_ns), CLK_NS));
      up2lo_cyc = GW'(ns_to_cyc(32'(pair.up2lo_ns), CLK_NS));
    end
  end
endmodule

// File: rtl/hb_down_timer.sv
`timescale 1ns/1ps
module hb_down_timer #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/hb_gate_seq.sv
`timescale 1ns/1ps
module hb_gate_seq import hb_gate_pkg::*; #(
  parameter int unsigned CLK_NS    = 4,
  parameter int unsigned MIN_ON_NS = 330,
  parameter int unsigned WAIT_NS   = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pgood,
  input  logic [1:0] pwm_cmd,
  input  logic       de_mode,
  input  logic       zero_cross,
  input  logic [1:0] dt_strap,
  input  logic [1:0] dt_code,
  input  logic       up_dis,
  input  logic       lo_dis,
  output logic       up_on,
  output logic       lo_on
);
  localparam int unsigned WAIT_CYC = ns_to_cyc(WAIT_NS, CLK_NS);
  localparam int unsigned MIN_CYC  = ns_to_cyc(MIN_ON_NS, CLK_NS);
  localparam int unsigned GAP_MAX  = max2(ns_to_cyc(DT_NS_MAX, CLK_NS), WAIT_CYC);
  localparam int unsigned GW       = $clog2(GAP_MAX + 1);
  localparam int unsigned MW       = $clog2(MIN_CYC + 1);

  seq_state_e state, nxt;

  logic          active, is_high, is_low, is_mid;
  logic          adaptive;
  logic [GW-1:0] lo2up_cyc, up2lo_cyc;
  logic          gap_load, gap_zero;
  logic [GW-1:0] gap_val;
  logic          min_load, min_done;

  // named events for the checks
  logic ev_go_up, ev_go_lo, ev_up_ready, ev_lo_ready, ev_wd_force, ev_zc_cut;

  assign active  = en && pgood;
  assign is_low  = (pwm_cmd == 2'b00);
  assign is_high = (pwm_cmd == 2'b01);
  assign is_mid  = pwm_cmd[1];

  hb_dt_table #(.CLK_NS(CLK_NS), .WAIT_CYC(WAIT_CYC), .GW(GW)) u_table (
    .dt_strap (dt_strap),
    .dt_code  (dt_code),
    .adaptive (adaptive),
    .lo2up_cyc(lo2up_cyc),
    .up2lo_cyc(up2lo_cyc)
  );

  hb_down_timer #(.W(GW)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .load_val(gap_val),
    .zero    (gap_zero)
  );

  hb_down_timer #(.W(MW)) u_min (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (min_load),
    .load_val(MW'(MIN_CYC - 1)),
    .zero    (min_done)
  );

  assign ev_up_ready = (state == S_GAP_UP) && (gap_zero || (adaptive && lo_dis));
  assign ev_lo_ready = (state == S_GAP_LO) && (gap_zero || (adaptive && up_dis));
  assign ev_wd_force = adaptive && gap_zero &&
                       (((state == S_GAP_UP) && !lo_dis) || ((state == S_GAP_LO) && !up_dis));
  assign ev_zc_cut   = (state == S_LO) && de_mode && min_done && is_low && zero_cross;

  always_comb begin
    nxt      = state;
    ev_go_up = 1'b0;
    ev_go_lo = 1'b0;
    if (!active) begin
      nxt = S_OFF;
    end else begin
      case (state)
        S_OFF, S_ZC: begin
          if (is_high)     ev_go_up = 1'b1;
          else if (is_mid) nxt = S_OFF;
          else if (state == S_OFF) ev_go_lo = 1'b1;
        end
        S_GAP_UP: begin
          if (is_low)           ev_go_lo = 1'b1;
          else if (is_mid)      nxt = S_OFF;
          else if (ev_up_ready) nxt = S_UP;
        end
        S_UP: begin
          if (is_low)      ev_go_lo = 1'b1;
          else if (is_mid) nxt = S_OFF;
        end
        S_GAP_LO: begin
          if (is_high)          ev_go_up = 1'b1;
          else if (is_mid)      nxt = S_OFF;
          else if (ev_lo_ready) nxt = S_LO;
        end
        S_LO: begin
          if (is_high)                               ev_go_up = 1'b1;
          else if (de_mode && min_done && is_mid)    nxt = S_OFF;
          else if (ev_zc_cut)                        nxt = S_ZC;
          else if (!de_mode && is_mid)               nxt = S_OFF;
        end
        default: nxt = S_OFF;
      endcase
      if (ev_go_up) nxt = S_GAP_UP;
      if (ev_go_lo) nxt = S_GAP_LO;
    end
  end

  assign gap_load = ev_go_up || ev_go_lo;
  assign gap_val  = ev_go_up ? (lo2up_cyc - 1'b1) : (up2lo_cyc - 1'b1);
  assign min_load = (nxt == S_LO) && (state != S_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_OFF;
    else        state <= nxt;
  end

  assign up_on = (state == S_UP);
  assign lo_on = (state == S_LO);

  p_inactive_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !pgood) |=> (!up_on && !lo_on));

  p_up_after_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_on) |-> !$past(lo_on));

  p_lo_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_on) |-> !$past(up_on));

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_on && lo_on));

  p_mid_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && is_mid && !de_mode) |=> (!up_on && !lo_on));

  p_zc_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && de_mode && lo_on && is_low && zero_cross && min_done) |=> !lo_on);

  p_min_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lo_on) && $past(active) && $past(de_mode) && !$past(is_high)) |-> $past(min_done));

  p_wd_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && is_high && ev_wd_force) |=> up_on);

  p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_GAP_UP) && is_low) |=> !up_on);
endmodule

// File: tb/test_hb_gate_seq.sv
`timescale 1ns/1ps
module test_hb_gate_seq;
  logic       clk = 1'b0;
  logic       rst_n, en, pgood, de_mode, zero_cross, up_dis, lo_dis;
  logic [1:0] pwm_cmd, dt_strap, dt_code;
  logic       up_on, lo_on;

  int n_chk = 0;
  int n_fail = 0;
  int overlaps = 0;
  int gap, cnt, lf, ul;
  bit done = 0;

  localparam int WD_EXP  = (100 + 3) / 4;
  localparam int MIN_EXP = (330 + 3) / 4;

  always #2 clk = ~clk;

  hb_gate_seq i_hb_gate_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .pgood(pgood), .pwm_cmd(pwm_cmd),
    .de_mode(de_mode), .zero_cross(zero_cross), .dt_strap(dt_strap),
    .dt_code(dt_code), .up_dis(up_dis), .lo_dis(lo_dis),
    .up_on(up_on), .lo_on(lo_on)
  );

  always @(negedge clk) if (up_on && lo_on) overlaps++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cyc(input int ns);
    return (ns + 3) / 4;
  endfunction

  // fixed pair in ns, written as a separate rule set from the design
  task automatic exp_pair(input int strap, input int code, output int a, output int b);
    int up2lo_vcc[4] = '{23, 18, 15, 7};
    int lo2up_gnd[4] = '{40, 25, 17, 17};
    if (strap == 2) begin a = 27; b = up2lo_vcc[code]; end
    else            begin a = lo2up_gnd[code]; b = 18; end
  endtask

  task automatic settle(input logic [1:0] c);
    pwm_cmd = c;
    repeat (40) @(negedge clk);
  endtask

  task automatic meas(input bit want_up, output int g);
    g = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (want_up ? up_on : lo_on) break;
      if (!up_on && !lo_on) g++;
    end
  endtask

  task automatic count_lo(output int c);
    c = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!lo_on) break;
      c++;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 1; pgood = 1; pwm_cmd = 2'b00; de_mode = 0; zero_cross = 0;
    dt_strap = 2'b10; dt_code = 0; up_dis = 0; lo_dis = 0;
    repeat (5) @(negedge clk);
    chk("R1 reset", int'(up_on | lo_on), 0);
    rst_n = 1;

    // R10 sweep over both fixed straps and all codes, measuring R2 and R3
    for (int s = 1; s <= 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        dt_strap = 2'(s); dt_code = 2'(c);
        exp_pair(s, c, lf, ul);
        settle(2'b00);
        pwm_cmd = 2'b01; meas(1, gap);
        chk($sformatf("R2 R10 strap%0d code%0d", s, c), gap, cyc(lf));
        pwm_cmd = 2'b00; meas(0, gap);
        chk($sformatf("R3 R10 strap%0d code%0d", s, c), gap, cyc(ul));
      end
    end

    // R8 adaptive
    dt_strap = 2'b00; up_dis = 1; lo_dis = 1;
    settle(2'b00);
    pwm_cmd = 2'b01; meas(1, gap); chk("R8 flag up", gap, 1);
    pwm_cmd = 2'b00; meas(0, gap); chk("R8 flag lo", gap, 1);
    up_dis = 0; lo_dis = 0;
    pwm_cmd = 2'b01; meas(1, gap); chk("R8 watchdog up", gap, WD_EXP);
    pwm_cmd = 2'b00; meas(0, gap); chk("R8 watchdog lo", gap, WD_EXP);
    dt_strap = 2'b11;
    pwm_cmd = 2'b01; repeat (3) @(negedge clk);
    lo_dis = 1; meas(1, gap); chk("R8 late flag", gap, 0);
    lo_dis = 0;

    // R9 reversal inside a fixed gap
    dt_strap = 2'b10; dt_code = 0;
    settle(2'b00);
    pwm_cmd = 2'b01; @(negedge clk);
    pwm_cmd = 2'b00; meas(0, gap);
    chk("R9 reversal", gap, cyc(23));

    // R5 mid command
    settle(2'b01);
    pwm_cmd = 2'b10; @(negedge clk);
    chk("R5 mid from up", int'(up_on | lo_on), 0);
    settle(2'b00);
    pwm_cmd = 2'b11; @(negedge clk);
    chk("R5 mid from lo", int'(up_on | lo_on), 0);
    repeat (10) @(negedge clk);
    chk("R5 mid held", int'(up_on | lo_on), 0);

    // R6 zero-cross ignored outside diode emulation
    settle(2'b00);
    zero_cross = 1; repeat (20) @(negedge clk);
    chk("R6 zc ignored", int'(lo_on), 1);
    zero_cross = 0;

    // R7 minimum on-time under mid command
    de_mode = 1;
    settle(2'b01);
    pwm_cmd = 2'b00; meas(0, gap);
    pwm_cmd = 2'b10; count_lo(cnt);
    chk("R7 hold before mid", cnt, MIN_EXP);

    // R7 early zero-cross waits for minimum, then R6 stays off
    settle(2'b01);
    pwm_cmd = 2'b00; meas(0, gap);
    zero_cross = 1; count_lo(cnt);
    chk("R7 hold before zc", cnt, MIN_EXP);
    zero_cross = 0; repeat (10) @(negedge clk);
    chk("R6 stays off", int'(lo_on | up_on), 0);
    pwm_cmd = 2'b01; meas(1, gap);
    chk("R2 after zc", gap, cyc(27));

    // R6 late zero-cross cuts on next edge
    pwm_cmd = 2'b00; meas(0, gap);
    repeat (100) @(negedge clk);
    chk("R6 before zc", int'(lo_on), 1);
    zero_cross = 1; @(negedge clk);
    chk("R6 zc cut", int'(lo_on), 0);
    zero_cross = 0;

    // R7 high command is not held
    settle(2'b01);
    pwm_cmd = 2'b00; meas(0, gap);
    pwm_cmd = 2'b01; @(negedge clk);
    chk("R7 high not held", int'(lo_on), 0);
    meas(1, gap);
    chk("R2 high in de", gap, cyc(27) - 1);
    de_mode = 0;

    // R1 enable and supply-good
    settle(2'b01);
    en = 0; @(negedge clk);
    chk("R1 en drop", int'(up_on | lo_on), 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      pwm_cmd = 2'(i % 3); @(negedge clk);
      cnt += int'(up_on | lo_on);
    end
    chk("R1 en held off", cnt, 0);
    en = 1; pgood = 0; cnt = 0;
    for (int i = 0; i < 20; i++) begin
      pwm_cmd = 2'(i % 3); @(negedge clk);
      cnt += int'(up_on | lo_on);
    end
    chk("R1 pgood held off", cnt, 0);

    // R11 restart with full gap
    pwm_cmd = 2'b01; @(negedge clk);
    pgood = 1; meas(1, gap);
    chk("R11 restart", gap, cyc(27));

    chk("R4 overlap", overlaps, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule